// File: doc/BRIEF.md
# Read/Write Turnaround Sequencer

This block sits on the controller side of a synchronous memory link where both ends have switchable input termination. It takes read and write requests over a valid/ready handshake. For each request it issues one memory command, made of a direction level (`cmdRead`), a load strobe (`cmdLoad`) and an address. Every cycle without an access still carries a direction level. That makes it one of two no-op kinds: a read-type no-op tells the memory to hold the data bus low, and a write-type no-op tells it to keep its termination on.

When the request direction changes, the sequencer finishes the old direction with a tail of old-type no-ops. The tail lasts long enough for the last data beat, plus a configurable margin. It then enters the new direction with a configurable run of new-type no-ops. As a result, neither end changes termination while the bus could float to mid-rail.

The block also drives the controller's own data pins. It puts write data on the bus a fixed number of cycles after each write command. It turns on its termination from one cycle before to one cycle after each expected read beat. At every other time it drives the bus low with termination off.

Top module: `rw_turnaround_seq`

## Requirements
- R1: While reset is held and right after it, `cmdRead`=1, `cmdLoad`=0, `reqReady`=0 and the pad mode is drive-low. After reset release the sequencer issues PRE_PAD read-type no-ops before it can accept a read.
- R2: An accepted request (`reqValid` and `reqReady` high at a rising edge) appears in the next cycle as `cmdLoad`=1, with `cmdRead` equal to the inverse of `reqWrite` and `cmdAddr` equal to `reqAddr`. Requests come out in acceptance order.
- R3: Requests of the current direction with no padding pending are accepted on consecutive cycles, giving back-to-back commands.
- R4: Before the first write after reads, exactly PRE_PAD write-type no-ops (`cmdLoad`=0, `cmdRead`=0) are issued immediately before the write command.
- R5: Before the first read after writes, exactly PRE_PAD read-type no-ops (`cmdLoad`=0, `cmdRead`=1) are issued immediately before the read command.
- R6: After the last command of one direction, old-type no-ops continue while a request of the other direction waits. For writes this lasts WR_LAT+POST_PAD cycles; for reads it lasts RD_LAT+1+POST_PAD cycles.
- R7: With no request pending, the sequencer issues the no-op type of the last access direction. Before any access, that type is read.
- R8: Write data is driven on `dqOut` with `dqDriveEn`=1 exactly WR_LAT cycles after its write command cycle, and in no other cycle.
- R9: `dqTermEn` is high exactly in cycles that lie RD_LAT-1, RD_LAT or RD_LAT+1 cycles after some read command. `rdValid` is high exactly RD_LAT cycles after a read command.
- R10: Exactly one pad mode is active at a time. When neither data drive nor termination is active, `dqDriveLow`=1 and `dqOut`=0.
- R11: `dqTermEn` changes value only in a cycle where the memory was given a read-type level in the previous cycle, so the memory is driving the bus.
- R12: `reqReady` is low while padding no-ops are being inserted and while a request of the other direction waits. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when valid |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqAddr | input | AW | Request address |
| reqData | input | DW | Write data for the request |
| cmdRead | output | 1 | Memory direction level, 1 = read / drive low, 0 = write / terminate |
| cmdLoad | output | 1 | 1 = access command this cycle, 0 = no-op |
| cmdAddr | output | AW | Command address |
| dqOut | output | DW | Controller data pin value |
| dqDriveEn | output | 1 | Controller drives valid write data |
| dqDriveLow | output | 1 | Controller drives the bus low, termination off |
| dqTermEn | output | 1 | Controller termination enabled |
| rdValid | output | 1 | Read data beat expected on the bus this cycle |

## Verification
Each direction is tried with back-to-back bursts, which separates the no-padding path from the padded one. Both direction switches are made with the new request presented in the cycle after the last access, which measures the tail and pre-pad counts exactly. A switch after a long idle gap shows that the tail is counted from the last access and not from when the request arrives. Tightly alternating read/write traffic and reads spaced a few cycles apart check that termination windows merge or split correctly and never overlap write data.

// File: rtl/turnseq_pkg.sv
package turnseq_pkg;

  // Strobes from the turnaround control to the command/pad datapath.
  typedef struct packed {
    logic issueLoad;  // register an access command this edge
    logic nextRead;   // direction level for the next command cycle
  } seqStrobe_t;

endpackage

// File: rtl/turnseq_ctrl.sv
module turnseq_ctrl
  import turnseq_pkg::*;
#(
  parameter int PRE_PAD  = 2,
  parameter int POST_PAD = 1,
  parameter int RD_LAT   = 3,
  parameter int WR_LAT   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  // Old-direction tails, counted in no-op cycles after the last access.
  localparam int RD_TAIL   = RD_LAT + 1 + POST_PAD;
  localparam int WR_TAIL   = WR_LAT + POST_PAD;
  localparam int SINCE_MAX = (RD_TAIL > WR_TAIL) ? RD_TAIL : WR_TAIL;
  localparam int SW        = $clog2(SINCE_MAX + 1);
  localparam int PW        = $clog2(PRE_PAD + 1);

  logic          dirWrite;   // current bus direction
  logic [PW-1:0] preLeft;    // entry no-ops still to issue
  logic [SW-1:0] since;      // no-op cycles since last access (saturating)

  logic padding, sameDir, tailMet, accept, flip;

  always_comb begin
    padding  = (preLeft != '0);
    sameDir  = (reqWrite == dirWrite);
    tailMet  = dirWrite ? (since >= SW'(WR_TAIL)) : (since >= SW'(RD_TAIL));
    reqReady = !padding && (!reqValid || sameDir);
    accept   = reqValid && reqReady;
    flip     = reqValid && !sameDir && !padding && tailMet;
    strobe.issueLoad = accept;
    strobe.nextRead  = (accept || flip) ? !reqWrite : !dirWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirWrite <= 1'b0;
      preLeft  <= PW'(PRE_PAD);
      since    <= SW'(SINCE_MAX);
    end else begin
      if (flip) begin
        dirWrite <= reqWrite;
        preLeft  <= PW'(PRE_PAD - 1);
      end else if (padding) begin
        preLeft  <= preLeft - PW'(1);
      end
      if (accept) begin
        since <= '0;
      end else if (since != SW'(SINCE_MAX)) begin
        since <= since + SW'(1);
      end
    end
  end

  AST_NO_ACCEPT_WHILE_PADDING: assert property (@(posedge clk) disable iff (!rstN)
    (preLeft != '0) |-> !reqReady); // R12

  AST_FLIP_LOADS_PREPAD: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrite != $past(dirWrite)) |-> (preLeft == PW'(PRE_PAD - 1))); // R4

  AST_NO_FLIP_RIGHT_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrite != $past(dirWrite)) |-> !$past(strobe.issueLoad)); // R6

endmodule

// File: rtl/turnseq_datapath.sv
module turnseq_datapath
  import turnseq_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 18,
  parameter int RD_LAT = 3,
  parameter int WR_LAT = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic          cmdRead,
  output logic          cmdLoad,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] dqOut,
  output logic          dqDriveEn,
  output logic          dqDriveLow,
  output logic          dqTermEn,
  output logic          rdValid
);

  localparam int RD_TOP = RD_LAT + 1;  // oldest read age of interest

  logic [DW-1:0]   cmdData;
  logic [RD_TOP:1] rdAge;               // bit k: read command k cycles ago
  logic [WR_LAT:1] wrAge;               // bit k: write command k cycles ago
  logic [DW-1:0]   wrDat [1:WR_LAT];
  logic            rdNow, wrNow;

  assign rdNow = cmdLoad && cmdRead;
  assign wrNow = cmdLoad && !cmdRead;

  // Command register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLoad <= 1'b0;
      cmdRead <= 1'b1;
      cmdAddr <= '0;
      cmdData <= '0;
    end else begin
      cmdLoad <= strobe.issueLoad;
      cmdRead <= strobe.nextRead;
      if (strobe.issueLoad) begin
        cmdAddr <= reqAddr;
        cmdData <= reqData;
      end
    end
  end

  // Read age pipeline.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdAge <= '0;
    else       rdAge <= {rdAge[RD_TOP-1:1], rdNow};
  end

  // Write age and data pipeline.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAge <= '0;
      for (int k = 1; k <= WR_LAT; k++) wrDat[k] <= '0;
    end else begin
      for (int k = WR_LAT; k > 1; k--) begin
        wrAge[k] <= wrAge[k-1];
        wrDat[k] <= wrDat[k-1];
      end
      wrAge[1] <= wrNow;
      wrDat[1] <= cmdData;
    end
  end

  // Controller pad modes.
  assign dqDriveEn  = wrAge[WR_LAT];
  assign dqTermEn   = rdAge[RD_LAT-1] | rdAge[RD_LAT] | rdAge[RD_LAT+1];
  assign dqDriveLow = !dqDriveEn && !dqTermEn;
  assign dqOut      = dqDriveEn ? wrDat[WR_LAT] : '0;
  assign rdValid    = rdAge[RD_LAT];

  AST_TERM_SWITCH_ON_LOW_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (dqTermEn != $past(dqTermEn)) |-> $past(cmdRead)); // R11

  AST_WRITE_INTO_TERMINATED: assert property (@(posedge clk) disable iff (!rstN)
    dqDriveEn |-> !$past(cmdRead)); // R6

  AST_PAD_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dqDriveEn && dqTermEn)); // R10

endmodule

// File: rtl/rw_turnaround_seq.sv
module rw_turnaround_seq
  import turnseq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 18,
  parameter int PRE_PAD  = 2,
  parameter int POST_PAD = 1,
  parameter int RD_LAT   = 3,
  parameter int WR_LAT   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic          cmdRead,
  output logic          cmdLoad,
  output logic [AW-1:0] cmdAddr,
  output logic [DW-1:0] dqOut,
  output logic          dqDriveEn,
  output logic          dqDriveLow,
  output logic          dqTermEn,
  output logic          rdValid
);

  seqStrobe_t strobe;

  turnseq_ctrl #(
    .PRE_PAD(PRE_PAD), .POST_PAD(POST_PAD), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  turnseq_datapath #(
    .AW(AW), .DW(DW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
  ) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqData(reqData),
    .cmdRead(cmdRead), .cmdLoad(cmdLoad), .cmdAddr(cmdAddr), .dqOut(dqOut),
    .dqDriveEn(dqDriveEn), .dqDriveLow(dqDriveLow), .dqTermEn(dqTermEn),
    .rdValid(rdValid)
  );

endmodule

// File: tb/rw_turnaround_seq_test.sv
module rw_turnaround_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 18, PRE_PAD = 2, POST_PAD = 1, RD_LAT = 3, WR_LAT = 2;
  localparam int HIST = 4096;
  localparam int WATCHDOG = 3000;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqReady, cmdRead, cmdLoad, dqDriveEn, dqDriveLow, dqTermEn, rdValid;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] dqOut;

  rw_turnaround_seq #(.AW(AW), .DW(DW), .PRE_PAD(PRE_PAD), .POST_PAD(POST_PAD),
                      .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .cmdRead(cmdRead), .cmdLoad(cmdLoad), .cmdAddr(cmdAddr), .dqOut(dqOut),
    .dqDriveEn(dqDriveEn), .dqDriveLow(dqDriveLow), .dqTermEn(dqTermEn),
    .rdValid(rdValid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: command history per cycle plus direction bookkeeping.
  bit            rdHist [0:HIST-1];
  bit            wrHist [0:HIST-1];
  logic [DW-1:0] wrDatHist [0:HIST-1];
  int    cyc = 0;
  bit    mDirW = 0;
  int    mPre = PRE_PAD;
  int    mSince = 1000;
  bit    eLoad = 0, eRead = 1, prevAcc = 0, prevAccW = 0, inResetWin = 1;
  logic [AW-1:0] eAddr = '0;
  string eTag = "R1";
  bit    prevTerm = 0, prevCmdRead = 1;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit termExp, drvExp, rdvExp, mReady, acc, fl;
      int tail;
      // command outputs
      chk({eTag, " cmdLoad"}, 32'(cmdLoad), 32'(eLoad));
      chk({eTag, " cmdRead"}, 32'(cmdRead), 32'(eRead));
      if (eLoad) chk("R2 cmdAddr", 32'(cmdAddr), 32'(eAddr));
      // pad modes from history
      termExp = 0;
      for (int k = RD_LAT - 1; k <= RD_LAT + 1; k++)
        if (cyc - k >= 0 && rdHist[cyc - k]) termExp = 1;
      drvExp = (cyc - WR_LAT >= 0) && wrHist[cyc - WR_LAT];
      rdvExp = (cyc - RD_LAT >= 0) && rdHist[cyc - RD_LAT];
      chk("R9 dqTermEn", 32'(dqTermEn), 32'(termExp));
      chk("R9 rdValid", 32'(rdValid), 32'(rdvExp));
      chk("R8 dqDriveEn", 32'(dqDriveEn), 32'(drvExp));
      if (drvExp) chk("R8 dqOut data", 32'(dqOut), 32'(wrDatHist[cyc - WR_LAT]));
      chk("R10 dqDriveLow", 32'(dqDriveLow), 32'(!drvExp && !termExp));
      if (!drvExp) chk("R10 dqOut low", 32'(dqOut), 32'd0);
      if (dqTermEn != prevTerm) chk("R11 term change on low bus", 32'(prevCmdRead), 32'd1);
      prevTerm = dqTermEn;
      prevCmdRead = cmdRead;
      // handshake
      mReady = (mPre == 0) && (!reqValid || (reqWrite == mDirW));
      chk(inResetWin ? "R1 reqReady" : "R12 reqReady", 32'(reqReady), 32'(mReady));
      acc  = reqValid && mReady;
      tail = mDirW ? (WR_LAT + POST_PAD) : (RD_LAT + 1 + POST_PAD);
      fl   = reqValid && (reqWrite != mDirW) && (mPre == 0) && (mSince >= tail);
      if (acc) begin
        eLoad = 1; eRead = !reqWrite; eAddr = reqAddr;
        eTag = (prevAcc && prevAccW == reqWrite) ? "R3" : "R2";
        rdHist[cyc + 1] = !reqWrite;
        wrHist[cyc + 1] = reqWrite;
        wrDatHist[cyc + 1] = reqData;
        mSince = 0; inResetWin = 0;
      end else begin
        eLoad = 0;
        if (fl) begin
          mDirW = reqWrite; mPre = PRE_PAD - 1; inResetWin = 0;
          eTag = mDirW ? "R4" : "R5";
        end else if (mPre > 0) begin
          mPre--;
          eTag = inResetWin ? "R1" : (mDirW ? "R4" : "R5");
        end else begin
          eTag = reqValid ? "R6" : "R7";
        end
        eRead = !mDirW;
        if (mSince < 1000) mSince++;
      end
      prevAcc = acc; prevAccW = reqWrite;
      cyc++;
      if (cyc >= WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
        finishRun();
      end
    end
  end

  // Driver: called and returns at posedge + 1.
  task automatic sendReq(input bit w, input logic [AW-1:0] a, input int gap);
    bit got;
    reqValid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    reqValid = 1'b1; reqWrite = w; reqAddr = a;
    reqData = DW'(a * 3 + 1);
    do begin
      @(negedge clk); got = reqReady;
      @(posedge clk); #1;
    end while (!got);
    reqValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < HIST; i++) begin rdHist[i] = 0; wrHist[i] = 0; wrDatHist[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset cmdRead", 32'(cmdRead), 32'd1);
    chk("R1 reset cmdLoad", 32'(cmdLoad), 32'd0);
    chk("R1 reset reqReady", 32'(reqReady), 32'd0);
    chk("R1 reset dqDriveLow", 32'(dqDriveLow), 32'd1);
    @(posedge clk); #1;
    rstN = 1'b1;
    // read right after reset, then back-to-back reads
    sendReq(0, 16'h0010, 0);
    sendReq(0, 16'h0011, 0);
    sendReq(0, 16'h0012, 0);
    sendReq(0, 16'h0013, 0);
    // read -> write switch presented immediately, then burst of writes
    sendReq(1, 16'h0100, 0);
    sendReq(1, 16'h0101, 0);
    sendReq(1, 16'h0102, 0);
    // write -> read switch presented immediately
    sendReq(0, 16'h0200, 0);
    // idle, then same-direction read
    sendReq(0, 16'h0201, 6);
    // long idle then write: tail already met
    sendReq(1, 16'h0300, 12);
    // tight alternation
    sendReq(0, 16'h0400, 0);
    sendReq(1, 16'h0401, 0);
    sendReq(0, 16'h0402, 0);
    sendReq(1, 16'h0403, 0);
    // spaced reads to split / merge termination windows
    sendReq(0, 16'h0500, 0);
    sendReq(0, 16'h0501, 2);
    sendReq(0, 16'h0502, 3);
    sendReq(0, 16'h0503, 1);
    repeat (20) @(posedge clk);
    finishRun();
  end

endmodule